// File: doc/BRIEF.md
# Transmit Page Reader

This block starts a frame transmission out of a paged packet memory. Software writes a start page, a byte count and, when wide addressing is on, an upper address half. It then sets the transmit command bit with a one-cycle request pulse. The block reads the frame one byte at a time through a read port with a one-cycle latency. It presents each byte on a byte stream with valid, ready and last.

After the last byte is taken, the block waits for the downstream sender to report whether the frame went out. It then writes a status code, raises the matching interrupt status bit and drops the command bit. A zero byte count ends the transmission at once, with no memory reads and no interrupt. A request made while the controller is held in reset or in loopback is dropped.

The interrupt output is the OR of the interrupt status bits masked by an enable vector. Status bits are cleared by pulsing 1s on a clear vector.

Top module: `txpage_reader`

## Requirements
- R1: After reset, the command bit, the status code, the interrupt status, the interrupt output, the stream valid and the memory read strobe are all 0.
- R2: A request pulse seen while `in_reset_i` or `loopback_i` is high is dropped. The command bit stays 0, the status code is unchanged and no memory read or stream byte follows.
- R3: An accepted request clears the status code to 0 and sets the command bit. Both are visible in the cycle after the pulse, and the command bit stays 1 until the transmission ends.
- R4: With a byte count of 0, no memory read and no stream byte occur. Two cycles after the pulse, the status code is 1 and the command bit is 0, and the interrupt status is unchanged.
- R5: The read address for byte index i is `page*256 + i`. When `wide_addr_i` is 1, `upper_addr_i*65536` is added; when it is 0, the upper address input has no effect. Reads are issued in increasing index order, one per byte.
- R6: The stream carries the bytes in index order, and each byte is the memory data returned one cycle after its read. `st_last_o` is 1 only on the final byte. While valid is high and ready is low, valid, data and last stay unchanged.
- R7: A completion reported as success sets the status code to 1 and interrupt status bit 1, and clears the command bit, all in the following cycle.
- R8: A completion reported as failure sets the status code to 8 and interrupt status bit 3, and clears the command bit, all in the following cycle.
- R9: `overlong_o` is 1 from the cycle after acceptance when the byte count is above 1518, and 0 when the count is 1518 or less. An overlong frame is still read and streamed in full.
- R10: `irq_o` equals the OR of `int_status_o & int_mask_i` in every cycle. A 1 on a bit of `int_clear_i` clears that status bit in the next cycle and leaves the others as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_reset_i | input | 1 | Controller held in its reset state |
| loopback_i | input | 1 | Controller in loopback mode |
| tx_go_i | input | 1 | One-cycle pulse that sets the transmit command bit |
| tx_page_i | input | 8 | Transmit start page |
| tx_count_i | input | 16 | Frame byte count |
| upper_addr_i | input | 16 | Upper address half |
| wide_addr_i | input | 1 | Adds the upper address half when 1 |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 32 | Memory read address |
| mem_data_i | input | 8 | Read data, one cycle after the strobe |
| st_data_o | output | 8 | Stream byte |
| st_valid_o | output | 1 | Stream byte valid |
| st_ready_i | input | 1 | Stream byte accepted |
| st_last_o | output | 1 | Final byte of the frame |
| done_valid_i | input | 1 | Downstream completion report |
| done_ok_i | input | 1 | Completion outcome, 1 for success |
| int_mask_i | input | 8 | Interrupt enable per status bit |
| int_clear_i | input | 8 | Write-1-to-clear pulses for interrupt status |
| cmd_tx_o | output | 1 | Transmit command bit |
| tx_status_o | output | 8 | Transmit status code |
| int_status_o | output | 8 | Interrupt status bits |
| irq_o | output | 1 | Interrupt request |
| overlong_o | output | 1 | Byte count of the current or last frame exceeds 1518 |

## Verification
A byte index off by one shows up on the next read strobe as a wrong address. It also shows up at the following stream handshake as a wrong byte or a misplaced last flag. A sequencer stuck in or skipping a phase shows within a cycle or two as a missing read, an extra read, a valid that drops while ready is low, or a command bit that clears early or never clears. A wrong completion code or a wrong interrupt bit is visible on the status ports one cycle after the completion report. A broken mask or clear path shows as an interrupt output that differs from the masked status in that same cycle.

// File: rtl/txpr_pkg.sv
package txpr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_EMPTY = 3'd1,
      PH_FETCH = 3'd2,
      PH_WAIT  = 3'd3,
      PH_HOLD  = 3'd4,
      PH_DONE  = 3'd5
   } txpr_phase_t;

   localparam int unsigned TSR_W   = 8;
   localparam logic [TSR_W-1:0] TSR_OK   = 8'h01;
   localparam logic [TSR_W-1:0] TSR_FAIL = 8'h08;
   localparam int unsigned OK_BIT   = 1;
   localparam int unsigned FAIL_BIT = 3;

endpackage

// File: rtl/txpr_addr_gen.sv
module txpr_addr_gen #(
   parameter int unsigned PAGE_W   = 8,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned HI_W     = 16,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned PAGE_SH  = 8,
   parameter bit          HAS_HIGH = 1'b1
) (
   input  logic [PAGE_W-1:0] page_i,
   input  logic [CNT_W-1:0]  idx_i,
   input  logic [HI_W-1:0]   hi_i,
   input  logic              wide_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int unsigned HI_SH = PAGE_W + PAGE_SH;

   logic [ADDR_W-1:0] low_addr;
   assign low_addr = (ADDR_W'(page_i) << PAGE_SH) + ADDR_W'(idx_i);

   generate
      if (HAS_HIGH) begin : g_high
         logic [ADDR_W-1:0] hi_part;
         assign hi_part = wide_i ? (ADDR_W'(hi_i) << HI_SH) : '0;
         assign addr_o  = low_addr + hi_part;
      end else begin : g_flat
         logic unused_hi;
         assign unused_hi = ^{hi_i, wide_i};
         assign addr_o    = low_addr;
      end
   endgenerate

   initial begin
      assert (HI_SH < ADDR_W) else $fatal(1, "address width too small for page field");
   end
endmodule

// File: rtl/txpr_out_reg.sv
module txpr_out_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              last_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              last_o,
   output logic              fire_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         last_o  <= 1'b0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         data_o  <= data_i;
         last_o  <= last_i;
      end else if (valid_o && ready_i) begin
         valid_o <= 1'b0;
      end
   end

   assign fire_o = valid_o && ready_i;

   AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o))); // R6

   initial begin
      assert (DATA_W >= 1) else $fatal(1, "data width must be positive");
   end
endmodule

// File: rtl/txpr_irq.sv
module txpr_irq #(
   parameter int unsigned ISR_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [ISR_W-1:0] set_i,
   input  logic [ISR_W-1:0] clr_i,
   input  logic [ISR_W-1:0] mask_i,
   output logic [ISR_W-1:0] isr_o,
   output logic             irq_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) isr_o <= '0;
      else         isr_o <= (isr_o & ~clr_i) | set_i;
   end

   assign irq_o = |(isr_o & mask_i);

   generate
      for (genvar b = 0; b < ISR_W; b++) begin : g_bit
         AST_W1C_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[b] && !set_i[b]) |=> !isr_o[b]); // R10
         AST_SET_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[b] |=> isr_o[b]); // R10
      end
   endgenerate
endmodule

// File: rtl/txpage_reader.sv
module txpage_reader
   import txpr_pkg::*;
#(
   parameter int unsigned PAGE_W    = 8,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned HI_W      = 16,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ISR_W     = 8,
   parameter int unsigned MAX_FRAME = 1518,
   parameter bit          HAS_HIGH  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_reset_i,
   input  logic              loopback_i,
   input  logic              tx_go_i,
   input  logic [PAGE_W-1:0] tx_page_i,
   input  logic [CNT_W-1:0]  tx_count_i,
   input  logic [HI_W-1:0]   upper_addr_i,
   input  logic              wide_addr_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [DATA_W-1:0] st_data_o,
   output logic              st_valid_o,
   input  logic              st_ready_i,
   output logic              st_last_o,
   input  logic              done_valid_i,
   input  logic              done_ok_i,
   input  logic [ISR_W-1:0]  int_mask_i,
   input  logic [ISR_W-1:0]  int_clear_i,
   output logic              cmd_tx_o,
   output logic [TSR_W-1:0]  tx_status_o,
   output logic [ISR_W-1:0]  int_status_o,
   output logic              irq_o,
   output logic              overlong_o
);
   localparam logic [CNT_W-1:0] LONG_LIMIT = CNT_W'(MAX_FRAME);

   txpr_phase_t       phase_q;
   logic [PAGE_W-1:0] page_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  idx_q;
   logic [HI_W-1:0]   hi_q;
   logic              wide_q;
   logic              cmd_q;
   logic [TSR_W-1:0]  tsr_q;
   logic              long_q;
   logic              accept;
   logic              final_byte;
   logic              fire;
   logic              load;
   logic [ISR_W-1:0]  isr_set;

   assign accept     = (phase_q == PH_IDLE) && tx_go_i && !in_reset_i && !loopback_i;
   assign final_byte = (idx_q == (cnt_q - 1'b1));
   assign mem_rd_o   = (phase_q == PH_FETCH);
   assign load       = (phase_q == PH_WAIT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         page_q  <= '0;
         cnt_q   <= '0;
         idx_q   <= '0;
         hi_q    <= '0;
         wide_q  <= 1'b0;
         cmd_q   <= 1'b0;
         tsr_q   <= '0;
         long_q  <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  page_q  <= tx_page_i;
                  cnt_q   <= tx_count_i;
                  hi_q    <= upper_addr_i;
                  wide_q  <= wide_addr_i;
                  idx_q   <= '0;
                  cmd_q   <= 1'b1;
                  tsr_q   <= '0;
                  long_q  <= (tx_count_i > LONG_LIMIT);
                  phase_q <= (tx_count_i == '0) ? PH_EMPTY : PH_FETCH;
               end
            end
            PH_EMPTY: begin
               tsr_q   <= TSR_OK;
               cmd_q   <= 1'b0;
               phase_q <= PH_IDLE;
            end
            PH_FETCH: phase_q <= PH_WAIT;
            PH_WAIT:  phase_q <= PH_HOLD;
            PH_HOLD: begin
               if (fire) begin
                  if (final_byte) begin
                     phase_q <= PH_DONE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     phase_q <= PH_FETCH;
                  end
               end
            end
            PH_DONE: begin
               if (done_valid_i) begin
                  tsr_q   <= done_ok_i ? TSR_OK : TSR_FAIL;
                  cmd_q   <= 1'b0;
                  phase_q <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      isr_set = '0;
      if ((phase_q == PH_DONE) && done_valid_i) begin
         isr_set[OK_BIT]   = done_ok_i;
         isr_set[FAIL_BIT] = !done_ok_i;
      end
   end

   txpr_addr_gen #(
      .PAGE_W   (PAGE_W),
      .CNT_W    (CNT_W),
      .HI_W     (HI_W),
      .ADDR_W   (ADDR_W),
      .PAGE_SH  (8),
      .HAS_HIGH (HAS_HIGH)
   ) i_addr (
      .page_i (page_q),
      .idx_i  (idx_q),
      .hi_i   (hi_q),
      .wide_i (wide_q),
      .addr_o (mem_addr_o)
   );

   txpr_out_reg #(
      .DATA_W (DATA_W)
   ) i_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .data_i  (mem_data_i),
      .last_i  (final_byte),
      .ready_i (st_ready_i),
      .valid_o (st_valid_o),
      .data_o  (st_data_o),
      .last_o  (st_last_o),
      .fire_o  (fire)
   );

   txpr_irq #(
      .ISR_W (ISR_W)
   ) i_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (isr_set),
      .clr_i  (int_clear_i),
      .mask_i (int_mask_i),
      .isr_o  (int_status_o),
      .irq_o  (irq_o)
   );

   assign cmd_tx_o    = cmd_q;
   assign tx_status_o = tsr_q;
   assign overlong_o  = long_q;

   AST_BUSY_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q != PH_IDLE) |-> cmd_q); // R3
   AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> (tsr_q == '0 && cmd_q)); // R3
   AST_IGNORED_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((phase_q == PH_IDLE) && tx_go_i && (in_reset_i || loopback_i)) |=> (!cmd_q && !mem_rd_o)); // R2
   AST_EMPTY_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && tx_count_i == '0) |=> ##1 (tsr_q == TSR_OK && !cmd_q && !mem_rd_o)); // R4
   AST_READ_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_rd_o |-> !st_valid_o); // R6
   AST_OK_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((phase_q == PH_DONE) && done_valid_i && done_ok_i) |=>
         (tsr_q == TSR_OK && int_status_o[OK_BIT] && !cmd_q)); // R7
   AST_FAIL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((phase_q == PH_DONE) && done_valid_i && !done_ok_i) |=>
         (tsr_q == TSR_FAIL && int_status_o[FAIL_BIT] && !cmd_q)); // R8

   initial begin
      assert (ISR_W > FAIL_BIT) else $fatal(1, "interrupt status too narrow");
      assert (CNT_W >= 2)       else $fatal(1, "count width too small");
      assert (MAX_FRAME < (2 ** CNT_W)) else $fatal(1, "frame limit exceeds count range");
   end
endmodule

// File: tb/test_txpage_reader.sv
module test_txpage_reader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_reset = 1'b0, loopback = 1'b0, tx_go = 1'b0;
   logic [7:0]  tx_page = '0;
   logic [15:0] tx_count = '0, upper_addr = '0;
   logic        wide_addr = 1'b0;
   logic        mem_rd;
   logic [31:0] mem_addr;
   logic [7:0]  mem_data = '0;
   logic [7:0]  st_data;
   logic        st_valid, st_last;
   logic        st_ready = 1'b0;
   logic        done_valid = 1'b0, done_ok = 1'b0;
   logic [7:0]  int_mask = '0, int_clear = '0;
   logic        cmd_tx;
   logic [7:0]  tx_status, int_status;
   logic        irq, overlong;

   int vectors = 0;
   int errors  = 0;
   int cycles  = 0;

   always #2 clk = ~clk;

   txpage_reader i_txpage_reader (
      .clk_i(clk), .rst_ni(rst_n), .in_reset_i(in_reset), .loopback_i(loopback),
      .tx_go_i(tx_go), .tx_page_i(tx_page), .tx_count_i(tx_count),
      .upper_addr_i(upper_addr), .wide_addr_i(wide_addr),
      .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
      .st_data_o(st_data), .st_valid_o(st_valid), .st_ready_i(st_ready),
      .st_last_o(st_last), .done_valid_i(done_valid), .done_ok_i(done_ok),
      .int_mask_i(int_mask), .int_clear_i(int_clear), .cmd_tx_o(cmd_tx),
      .tx_status_o(tx_status), .int_status_o(int_status), .irq_o(irq),
      .overlong_o(overlong)
   );

   function automatic logic [7:0] mem_fn(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
   endfunction

   // behavioural memory with one cycle of read latency
   always @(posedge clk) if (mem_rd) mem_data <= mem_fn(mem_addr);

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL WDOG: actual %0d cycles expected completion", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // advance to the next falling edge and apply the every-cycle comparisons
   task automatic cyc();
      @(negedge clk);
      chk("R10 irq", irq, |(int_status & int_mask));
      if (cmd_tx === 1'b0) chk("R6 idle-valid", st_valid, 1'b0);
   endtask

   task automatic run_frame(input logic [7:0] page, input logic [15:0] count,
                            input logic [15:0] hi, input logic wide,
                            input logic ok, input logic rnd_ready);
      logic [31:0] base;
      logic [7:0]  exp_q[$];
      logic [7:0]  isr_before;
      logic [7:0]  held_data;
      logic        held_last;
      logic        held;
      int          reads;
      int          got;
      base = (wide ? ({16'h0, hi} << 16) : 32'h0) + ({24'h0, page} << 8);
      for (int i = 0; i < count; i++) exp_q.push_back(mem_fn(base + 32'(i)));
      isr_before = int_status;
      tx_page = page; tx_count = count; upper_addr = hi; wide_addr = wide;
      tx_go = 1'b1;
      cyc();
      tx_go = 1'b0;
      chk("R3 cmd set", cmd_tx, 1'b1);
      chk("R3 status cleared", tx_status, 8'h00);
      chk("R9 overlong flag", overlong, (count > 16'd1518));
      if (count == 16'd0) begin
         chk("R4 no read", mem_rd, 1'b0);
         cyc();
         chk("R4 status one", tx_status, 8'h01);
         chk("R4 cmd cleared", cmd_tx, 1'b0);
         chk("R4 isr unchanged", int_status, isr_before);
         chk("R4 no read after", mem_rd, 1'b0);
         chk("R4 no stream", st_valid, 1'b0);
         return;
      end
      reads = 0; got = 0; held = 1'b0; held_data = '0; held_last = 1'b0;
      while (got < count) begin
         if (mem_rd) begin
            chk("R5 read address", mem_addr, base + 32'(reads));
            reads++;
         end
         if (held) begin
            chk("R6 valid held", st_valid, 1'b1);
            chk("R6 data held", st_data, held_data);
            chk("R6 last held", st_last, held_last);
         end
         st_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
         held = 1'b0;
         if (st_valid) begin
            if (st_ready) begin
               chk("R6 stream byte", st_data, exp_q.pop_front());
               chk("R6 last flag", st_last, (got == count - 1));
               got++;
            end else begin
               held = 1'b1; held_data = st_data; held_last = st_last;
            end
         end
         chk("R3 cmd busy", cmd_tx, 1'b1);
         cyc();
      end
      st_ready = 1'b0;
      chk("R5 read count", reads, count);
      chk("R9 flag kept", overlong, (count > 16'd1518));
      done_valid = 1'b1; done_ok = ok;
      cyc();
      done_valid = 1'b0;
      chk("R5 no extra read", mem_rd, 1'b0);
      if (ok) begin
         chk("R7 status ok", tx_status, 8'h01);
         chk("R7 isr bit1", int_status[1], 1'b1);
         chk("R7 cmd cleared", cmd_tx, 1'b0);
      end else begin
         chk("R8 status fail", tx_status, 8'h08);
         chk("R8 isr bit3", int_status[3], 1'b1);
         chk("R8 cmd cleared", cmd_tx, 1'b0);
      end
   endtask

   task automatic ignored_go(input logic rst_mode);
      logic [7:0] st_before;
      st_before = tx_status;
      in_reset = rst_mode; loopback = !rst_mode;
      tx_count = 16'd4; tx_page = 8'h33;
      tx_go = 1'b1;
      cyc();
      tx_go = 1'b0; in_reset = 1'b0; loopback = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk("R2 cmd stays low", cmd_tx, 1'b0);
         chk("R2 no read", mem_rd, 1'b0);
         chk("R2 no stream", st_valid, 1'b0);
         chk("R2 status kept", tx_status, st_before);
         cyc();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 cmd", cmd_tx, 1'b0);
      rst_n = 1'b1;
      cyc();
      chk("R1 status", tx_status, 8'h00);
      chk("R1 isr", int_status, 8'h00);
      chk("R1 irq", irq, 1'b0);
      chk("R1 valid", st_valid, 1'b0);
      chk("R1 read", mem_rd, 1'b0);

      ignored_go(1'b1);
      ignored_go(1'b0);

      run_frame(8'h12, 16'd5, 16'h0000, 1'b0, 1'b1, 1'b0);
      run_frame(8'h40, 16'd7, 16'h00AB, 1'b1, 1'b0, 1'b1);
      run_frame(8'h21, 16'd3, 16'h1234, 1'b0, 1'b1, 1'b1);
      run_frame(8'hFF, 16'd300, 16'h0001, 1'b1, 1'b1, 1'b1);
      run_frame(8'h05, 16'd1, 16'h0000, 1'b0, 1'b0, 1'b1);
      run_frame(8'h50, 16'd0, 16'h0000, 1'b0, 1'b1, 1'b0);

      // mask and write-1-to-clear
      chk("R10 isr both set", int_status, 8'h0A);
      int_mask = 8'h08;
      cyc();
      chk("R10 irq masked on", irq, 1'b1);
      int_clear = 8'h02;
      cyc();
      int_clear = 8'h00;
      chk("R10 clear bit1 only", int_status, 8'h08);
      int_mask = 8'h02;
      cyc();
      chk("R10 irq masked off", irq, 1'b0);
      int_clear = 8'h08;
      cyc();
      int_clear = 8'h00;
      chk("R10 all cleared", int_status, 8'h00);
      int_mask = 8'hFF;
      cyc();

      run_frame(8'h10, 16'd1518, 16'h0000, 1'b0, 1'b1, 1'b0);
      run_frame(8'h20, 16'd1519, 16'h0000, 1'b0, 1'b1, 1'b0);
      chk("R10 irq after ok", irq, 1'b1);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule